// File: doc/BRIEF.md
# Code Flash Programming Sequencer

This block runs the programming operations of an on-chip code flash array. A host presents an address, a data byte and a mode code, then strobes an active-low program pulse. A byte write or a lock-bit write starts when the pulse is released. The block then times the operation itself and shows its progress in two ways: on a ready/busy output, and through data polling on the read path. A chip erase needs the pulse held low for a set number of cycles. The erase then sweeps the whole array to all ones, one byte per cycle.

The array is a synchronous RAM model that behaves like flash: a write can only clear bits, so the stored byte is the AND of the old byte and the new data. The read path returns code bytes or fixed identification bytes, and it hides code when protection is set. Every duration is a cycle-count parameter, so a bench can use short times. Mode codes on `mode_i`: 0 = read code, 1 = byte write, 2 = chip erase, 3 = identification read, 4 = lock write. Every other code is inert.

Top module: `flash_prog_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rdy_o` is 1 and `dout_o` is 8'h00. Reset clears both protection bits and leaves the array untouched.
- R2: In mode 1 or 4, the first clock edge that samples `prog_n_i` high after it was low starts an operation if the block is idle. `rdy_o` is 0 from that edge for exactly WRITE_CYC cycles, then returns to 1.
- R3: A byte write stores the old byte AND `din_i`, so it can clear bits but never set them.
- R4: During a byte write, a mode-0 read of the address being written returns the complement of the written bit 7 in bit 7 and the current array content in bits 6:0. A read of any other address returns normal data.
- R5: A pulse edge of any kind that arrives while the block is busy is ignored. The operation under way and the array are unchanged.
- R6: In mode 2, if `prog_n_i` is sampled low on ERASE_HOLD consecutive edges, beginning at a high-to-low transition while idle, the erase starts. `rdy_o` is then 0 for 2^ADDR_W cycles, after which every byte reads 8'hFF and both protection bits are clear.
- R7: If the pulse is released before ERASE_HOLD low samples, the erase is aborted. `rdy_o` stays 1 and the array is unchanged.
- R8: In mode 3, address 8'h30 returns 8'h1E and 8'h31 returns 8'h51. Address 8'h32 returns 8'hFF when `hv_i` is 1 and 8'h05 when it is 0. Every other address returns 8'h00.
- R9: A mode-4 operation ORs `din_i[0]` and `din_i[1]` into the two protection bits when its timed period ends. While either bit is set, mode-0 reads outside polling return 8'h00. No mode reads the bits back, and mode-3 reads are unaffected.
- R10: `dout_o` reflects the mode and address sampled two edges earlier. In modes other than 0 and 3 it is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operation select code |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | 8 | Data byte or protection bits |
| prog_n_i | input | 1 | Active-low program pulse |
| hv_i | input | 1 | High programming voltage indicator |
| dout_o | output | 8 | Registered read data |
| rdy_o | output | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the block with ADDR_W = 6, WRITE_CYC = 8 and ERASE_HOLD = 12. The 64-byte array makes a full erase sweep short enough to run several times, and the last address, 63, is easy to reach. Even at this width, the identification addresses 8'h30 to 8'h32 still decode. Eight-cycle writes leave room to poll, and to send a second, ignored pulse, inside a single busy window. A hold limit of 12 allows an exact comparison of an erase held for the full count against one released a cycle early.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_WRITE = 3'd1,
    M_ERASE = 3'd2,
    M_SIG   = 3'd3,
    M_LOCK  = 3'd4
  } fp_mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_HOLD,
    S_SWEEP
  } fp_state_e;

  localparam logic [7:0] ID_MAKER = 8'h1E;
  localparam logic [7:0] ID_PART  = 8'h51;
  localparam logic [7:0] ID_HV    = 8'hFF;
  localparam logic [7:0] ID_LV    = 8'h05;
endpackage

// File: rtl/fps_array.sv
module fps_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // read-first single-clock RAM, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int WRITE_CYC  = 20,
  parameter int ERASE_HOLD = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        din_i,
  input  logic              prog_n_i,
  input  logic [7:0]        rdata_i,
  output logic              rdy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o,
  output logic              poll_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              pbit_o,
  output logic              locked_o
);
  localparam int CNT_W  = $clog2(WRITE_CYC + 1);
  localparam int HCNT_W = $clog2(ERASE_HOLD + 1);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  fp_state_e         state;
  logic              prog_q;
  logic [CNT_W-1:0]  cnt;
  logic [HCNT_W-1:0] hcnt;
  logic [ADDR_W-1:0] saddr;
  logic [ADDR_W-1:0] wa_q;
  logic [7:0]        wd_q;
  logic [7:0]        old_q;
  logic              is_lock;
  logic              first_q;
  logic [1:0]        lock_q;
  logic              rdy_q;

  logic       prog_rise, prog_fall;
  logic [7:0] old_sel;

  assign prog_rise = prog_n_i & ~prog_q;
  assign prog_fall = ~prog_n_i & prog_q;
  assign old_sel   = first_q ? rdata_i : old_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      prog_q  <= 1'b1;
      cnt     <= '0;
      hcnt    <= '0;
      saddr   <= '0;
      wa_q    <= '0;
      wd_q    <= '0;
      old_q   <= '0;
      is_lock <= 1'b0;
      first_q <= 1'b0;
      lock_q  <= 2'b00;
      rdy_q   <= 1'b1;
    end else begin
      prog_q <= prog_n_i;
      case (state)
        S_IDLE: begin
          if (prog_rise && (mode_i == M_WRITE || mode_i == M_LOCK)) begin
            state   <= S_WAIT;
            cnt     <= CNT_W'(WRITE_CYC - 1);
            wa_q    <= addr_i;
            wd_q    <= din_i;
            is_lock <= (mode_i == M_LOCK);
            first_q <= 1'b1;
            rdy_q   <= 1'b0;
          end else if (prog_fall && mode_i == M_ERASE) begin
            state <= S_HOLD;
            hcnt  <= HCNT_W'(1);
          end
        end
        S_WAIT: begin
          first_q <= 1'b0;
          if (first_q) old_q <= rdata_i;
          if (cnt == '0) begin
            state <= S_IDLE;
            rdy_q <= 1'b1;
            if (is_lock) lock_q <= lock_q | wd_q[1:0];
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          if (prog_n_i) begin
            state <= S_IDLE;
          end else if (hcnt == HCNT_W'(ERASE_HOLD - 1)) begin
            state <= S_SWEEP;
            saddr <= '0;
            rdy_q <= 1'b0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: begin
          if (saddr == LAST) begin
            state  <= S_IDLE;
            rdy_q  <= 1'b1;
            lock_q <= 2'b00;
          end else begin
            saddr <= saddr + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    we_o    = (state == S_SWEEP) || (state == S_WAIT && cnt == '0 && !is_lock);
    waddr_o = (state == S_SWEEP) ? saddr : wa_q;
    wdata_o = (state == S_SWEEP) ? 8'hFF : (old_sel & wd_q);
  end

  assign rdy_o    = rdy_q;
  assign poll_o   = (state == S_WAIT) && !is_lock;
  assign paddr_o  = wa_q;
  assign pbit_o   = ~wd_q[7];
  assign locked_o = |lock_q;

  // R2: busy stays low while the timer still runs
  assert_busy_window_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && cnt != '0) |=> !rdy_o);

  // R5: a pulse during a timed operation leaves the latched operands alone
  assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && (prog_rise || prog_fall)) |=> ($stable(wa_q) && $stable(wd_q)));

  // R6: the sweep runs with the busy indication low
  assert_sweep_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (state == S_SWEEP) |-> !rdy_o);

  // R7: early release returns to idle with nothing written
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD && prog_n_i) |=> (state == S_IDLE && rdy_o && !we_o));
endmodule

// File: rtl/fps_rdmux.sv
module fps_rdmux
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hv_i,
  input  logic [7:0]        rdata_i,
  input  logic              poll_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic              pbit_i,
  input  logic              locked_i,
  output logic [7:0]        dout_o
);
  localparam logic [ADDR_W-1:0] ID_A0 = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] ID_A1 = ADDR_W'(8'h31);
  localparam logic [ADDR_W-1:0] ID_A2 = ADDR_W'(8'h32);

  logic [2:0]        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              hv_q;
  logic [7:0]        nxt;
  logic              hit;

  assign hit = poll_i && (addr_q == paddr_i);

  always_comb begin
    nxt = 8'h00;
    if (mode_q == M_SIG) begin
      if (addr_q == ID_A0)      nxt = ID_MAKER;
      else if (addr_q == ID_A1) nxt = ID_PART;
      else if (addr_q == ID_A2) nxt = hv_q ? ID_HV : ID_LV;
    end else if (mode_q == M_READ) begin
      if (hit)           nxt = {pbit_i, rdata_i[6:0]};
      else if (locked_i) nxt = 8'h00;
      else               nxt = rdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 3'b111;
      addr_q <= '0;
      hv_q   <= 1'b0;
      dout_o <= 8'h00;
    end else begin
      mode_q <= mode_i;
      addr_q <= addr_i;
      hv_q   <= hv_i;
      dout_o <= nxt;
    end
  end

  // R8: maker identification byte
  assert_id_maker_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SIG && addr_q == ID_A0) |=> (dout_o == 8'h1E));

  // R9: protected code reads as zero
  assert_locked_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_READ && locked_i && !hit) |=> (dout_o == 8'h00));

  // R10: inert modes drive zero
  assert_inert_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_q != M_READ && mode_q != M_SIG) |=> (dout_o == 8'h00));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ADDR_W     = 10,
  parameter int WRITE_CYC  = 20,
  parameter int ERASE_HOLD = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        din_i,
  input  logic              prog_n_i,
  input  logic              hv_i,
  output logic [7:0]        dout_o,
  output logic              rdy_o
);
  logic [7:0]        rdata;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wdata;
  logic              poll;
  logic [ADDR_W-1:0] paddr;
  logic              pbit;
  logic              locked;

  fps_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .raddr (addr_i),
    .rdata (rdata),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata)
  );

  fps_ctrl #(
    .ADDR_W     (ADDR_W),
    .WRITE_CYC  (WRITE_CYC),
    .ERASE_HOLD (ERASE_HOLD)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_i),
    .addr_i   (addr_i),
    .din_i    (din_i),
    .prog_n_i (prog_n_i),
    .rdata_i  (rdata),
    .rdy_o    (rdy_o),
    .we_o     (we),
    .waddr_o  (waddr),
    .wdata_o  (wdata),
    .poll_o   (poll),
    .paddr_o  (paddr),
    .pbit_o   (pbit),
    .locked_o (locked)
  );

  fps_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_i),
    .addr_i   (addr_i),
    .hv_i     (hv_i),
    .rdata_i  (rdata),
    .poll_i   (poll),
    .paddr_i  (paddr),
    .pbit_i   (pbit),
    .locked_i (locked),
    .dout_o   (dout_o)
  );
endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
  localparam int AW = 6;
  localparam int WC = 8;
  localparam int EH = 12;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode = 3'd2;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00;
  logic          prog_n = 1'b1;
  logic          hv = 1'b1;
  logic [7:0]    dout;
  logic          rdy;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  flash_prog_seq #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_HOLD(EH)) i_flash_prog_seq (
    .clk(clk), .rst(rst), .mode_i(mode), .addr_i(addr), .din_i(din),
    .prog_n_i(prog_n), .hv_i(hv), .dout_o(dout), .rdy_o(rdy)
  );

  // behavioural reference model: state 0 idle, 1 timed, 2 hold, 3 sweep
  int         mstate = 0;
  int         rem = 0;
  int         hcnt = 0;
  int         sw = 0;
  int         wa = 0;
  logic [7:0] wd = 8'h00;
  bit         wlock = 1'b0;
  logic [1:0] mlock = 2'b00;
  bit         pprev = 1'b1;
  bit         exp_rdy = 1'b1;
  logic [7:0] mmem [DEPTH];

  always @(posedge clk) begin
    if (rst) begin
      mstate = 0; exp_rdy = 1'b1; pprev = 1'b1; mlock = 2'b00;
    end else begin
      case (mstate)
        0: begin
          if (prog_n && !pprev && (mode == 3'd1 || mode == 3'd4)) begin
            mstate = 1; rem = WC; exp_rdy = 1'b0;
            wa = int'(addr); wd = din; wlock = (mode == 3'd4);
          end else if (!prog_n && pprev && mode == 3'd2) begin
            mstate = 2; hcnt = 1;
          end
        end
        1: begin
          rem--;
          if (rem == 0) begin
            if (wlock) mlock = mlock | wd[1:0];
            else mmem[wa] = mmem[wa] & wd;
            exp_rdy = 1'b1; mstate = 0;
          end
        end
        2: begin
          if (prog_n) mstate = 0;
          else begin
            hcnt++;
            if (hcnt == EH) begin mstate = 3; sw = 0; exp_rdy = 1'b0; end
          end
        end
        default: begin
          mmem[sw] = 8'hFF;
          if (sw == DEPTH - 1) begin mstate = 0; exp_rdy = 1'b1; mlock = 2'b00; end
          else sw++;
        end
      endcase
      pprev = prog_n;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ready/busy compared against the model on every cycle (R2, R6, R7)
  always @(negedge clk) begin
    if (!rst && !done) chk("R2/R6/R7 rdy per cycle", {7'd0, rdy}, {7'd0, exp_rdy});
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [2:0] m, int a, logic [7:0] exp, string tag);
    mode = m; addr = AW'(a);
    tick(3);
    chk(tag, dout, exp);
  endtask

  task automatic pulse(logic [2:0] m, int a, logic [7:0] d);
    mode = m; addr = AW'(a); din = d;
    prog_n = 1'b0; tick(1);
    prog_n = 1'b1; tick(1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && mstate != 0; i++) tick(1);
    tick(1);
  endtask

  task automatic erase(int hold);
    mode = 3'd2; prog_n = 1'b0;
    tick(hold);
    prog_n = 1'b1; tick(1);
    wait_idle();
  endtask

  initial begin
    tick(4);
    chk("R1 dout in reset", dout, 8'h00);
    chk("R1 rdy in reset", {7'd0, rdy}, 8'h01);
    rst = 1'b0;
    tick(1);
    chk("R1 dout after reset", dout, 8'h00);

    // R6 full erase
    erase(EH);
    rd(3'd0, 0, 8'hFF, "R6 erased byte 0");
    rd(3'd0, 63, 8'hFF, "R6 erased byte 63");
    rd(3'd0, 17, 8'hFF, "R6 erased byte 17");

    // R8 identification bytes
    hv = 1'b1;
    rd(3'd3, 'h30, 8'h1E, "R8 maker");
    rd(3'd3, 'h31, 8'h51, "R8 part");
    rd(3'd3, 'h32, 8'hFF, "R8 hv");
    rd(3'd3, 'h33, 8'h00, "R8 other address");
    hv = 1'b0;
    rd(3'd3, 'h32, 8'h05, "R8 lv");
    hv = 1'b1;

    // R2/R4 write with polling
    pulse(3'd1, 5, 8'hA5);
    rd(3'd0, 5, 8'h7F, "R4 polling same address");
    rd(3'd0, 6, 8'hFF, "R4 other address normal");
    wait_idle();
    rd(3'd0, 5, 8'hA5, "R2 written byte");

    // R3 clear-only write
    pulse(3'd1, 5, 8'hF0);
    wait_idle();
    rd(3'd0, 5, 8'hA0, "R3 AND of old and new");

    // R5 pulse during busy ignored
    pulse(3'd1, 7, 8'h3C);
    rd(3'd0, 7, 8'hFF, "R4 polling bit7 complement of 0");
    pulse(3'd1, 8, 8'h00);
    wait_idle();
    rd(3'd0, 8, 8'hFF, "R5 ignored write target");
    rd(3'd0, 7, 8'h3C, "R5 first write intact");

    // R7 early release aborts
    erase(EH - 1);
    rd(3'd0, 5, 8'hA0, "R7 array unchanged");
    rd(3'd0, 7, 8'h3C, "R7 array unchanged 2");

    // R10 inert modes
    rd(3'd5, 5, 8'h00, "R10 inert code 5");
    rd(3'd1, 5, 8'h00, "R10 write mode reads zero");

    // R9 protection
    pulse(3'd4, 0, 8'h01);
    wait_idle();
    rd(3'd0, 5, 8'h00, "R9 locked code hidden");
    rd(3'd3, 'h30, 8'h1E, "R9 id still readable");

    // R6 erase clears protection
    erase(EH + 3);
    rd(3'd0, 5, 8'hFF, "R6 unlocked and erased");

    // R3 boundary at the last address
    pulse(3'd1, 63, 8'h12);
    wait_idle();
    rd(3'd0, 63, 8'h12, "R3 last address write");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      ntests++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule